// File: doc/BRIEF.md
# Reset Source and Start-up Controller

This block decides how a small microcontroller core comes out of reset. It watches power-on, an external reset pin, the watchdog time-out, and three strobes from the core: HALT entry, watchdog clear, and wake. Each event leads to one of three start-up kinds. A cold start re-initialises the whole core. A warm start re-initialises only the program counter and the stack pointer. A plain wake re-initialises nothing.

Every start-up holds the CPU off with a run enable for a fixed number of oscillator cycles. During that window the controller raises the matching reset output. Two sticky flags, a time-out flag and a power-down flag, form a two-bit code. Firmware reads this code after start-up to learn which of the five reset causes occurred.

Top module: `rstseq_top`

## Requirements
- R1: While `porN` is low, the flags read {flagTo,flagPd}=00, `coldRst` is 1 and `cpuRun` is 0, asynchronously, whatever the other inputs are. Power-on outranks every other event.
- R2: After any qualifying event (power-on release, pin reset release, watchdog time-out, wake from HALT), the start-up counter restarts at 0. `cpuRun` rises exactly 2^CNT_W clock edges after the event edge (1024 by default).
- R3: In run mode, `haltCmd` enters HALT and sets flagPd. `cpuRun` is 0 while halted. `wdtClr` in run mode clears flagPd. If both arrive together, `haltCmd` wins.
- R4: A watchdog time-out in run mode starts a cold start-up (`coldRst`=1), sets flagTo and leaves flagPd unchanged.
- R5: A watchdog time-out in HALT starts a warm start-up: `warmRst`=1, `coldRst`=0, and the flags become 11.
- R6: `wakeEvt` in HALT starts a start-up with both reset outputs at 0 and leaves the flags unchanged.
- R7: The reset pin (`pinRstN`, active low) passes through a two-stage synchronizer. `coldRst` rises on the third edge after the pin falls and stays high while the pin is low. A pin reset in run mode leaves the flags unchanged.
- R8: A pin reset that arrives while halted sets the flags to 01.
- R9: During a start-up, `wdtTimeout`, `haltCmd`, `wdtClr` and `wakeEvt` have no effect on the flags or on the timing. In run mode, `wakeEvt` has no effect.
- R10: When several events arrive in the same cycle, the pin reset wins over a watchdog time-out, and a watchdog time-out wins over a wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oscillator clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| pinRstN | input | 1 | External reset pin, active low, asynchronous |
| wdtTimeout | input | 1 | Watchdog expiry strobe |
| haltCmd | input | 1 | HALT instruction strobe |
| wdtClr | input | 1 | Watchdog-clear instruction strobe |
| wakeEvt | input | 1 | Port or interrupt wake strobe |
| coldRst | output | 1 | Full core reset, high during a cold start-up |
| warmRst | output | 1 | PC and SP reset, high during a warm start-up |
| cpuRun | output | 1 | CPU run enable |
| flagTo | output | 1 | Time-out flag |
| flagPd | output | 1 | Power-down flag |

## Verification
The bench builds the block with a 5-bit start-up counter. It sweeps all 16 combinations of the four strobes, once from run mode and once from HALT. Expected outputs and flags are worked out arithmetically from the priority rules. This separates:
- the cold, warm and plain-wake start-ups from one another;
- a time-out from a wake;
- events that must be ignored from events that must act.

Directed sequences then walk the five reset causes in turn and check that each leaves its own flag code. They also check the start-up length edge by edge, with strobes injected part-way through to confirm they are ignored. Finally they cover the synchronizer latency of the pin, a pin reset that coincides with a watchdog time-out, and power-on arriving in the middle of a run.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {MODE_RUN, MODE_HALT, MODE_START} mode_e;
  typedef enum logic [1:0] {KIND_COLD, KIND_WARM, KIND_WAKE} kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic toSet;
    logic toClr;
    logic pdSet;
    logic pdClr;
  } dpCmd_t;
endpackage

// File: rtl/rstseq_dp.sv
module rstseq_dp
  import rstseq_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic   clk,
  input  logic   porN,
  input  dpCmd_t cmd,
  output logic   cntDone,
  output logic   flagTo,
  output logic   flagPd
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)            cnt <= '0;
    else if (cmd.cntClr)  cnt <= '0;
    else if (cmd.cntInc)  cnt <= cnt + 1'b1;
  end

  assign cntDone = (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      flagTo <= 1'b0;
      flagPd <= 1'b0;
    end else begin
      if (cmd.toSet)      flagTo <= 1'b1;
      else if (cmd.toClr) flagTo <= 1'b0;
      if (cmd.pdSet)      flagPd <= 1'b1;
      else if (cmd.pdClr) flagPd <= 1'b0;
    end
  end

  assert_cnt_restart_R2: assert property (@(posedge clk) disable iff (!porN)
    cmd.cntClr |=> (cnt == '0));

  assert_to_set_R4: assert property (@(posedge clk) disable iff (!porN)
    cmd.toSet |=> flagTo);
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   porN,
  input  logic   pinRstN,
  input  logic   wdtTimeout,
  input  logic   haltCmd,
  input  logic   wdtClr,
  input  logic   wakeEvt,
  input  logic   cntDone,
  output dpCmd_t cmd,
  output logic   cpuRun,
  output logic   coldRst,
  output logic   warmRst
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic  pinLow;
  mode_e mode, modeNext;
  kind_e kind, kindNext;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinRstN};
  end

  assign pinLow = ~syncQ[SYNC_STAGES-1];

  always_comb begin
    modeNext = mode;
    kindNext = kind;
    cmd      = '0;
    if (pinLow) begin
      modeNext   = MODE_START;
      kindNext   = KIND_COLD;
      cmd.cntClr = 1'b1;
      if (mode == MODE_HALT) begin
        cmd.toClr = 1'b1;
        cmd.pdSet = 1'b1;
      end
    end else begin
      case (mode)
        MODE_RUN: begin
          if (wdtTimeout) begin
            modeNext   = MODE_START;
            kindNext   = KIND_COLD;
            cmd.cntClr = 1'b1;
            cmd.toSet  = 1'b1;
          end else if (haltCmd) begin
            modeNext  = MODE_HALT;
            cmd.pdSet = 1'b1;
          end else if (wdtClr) begin
            cmd.pdClr = 1'b1;
          end
        end
        MODE_HALT: begin
          if (wdtTimeout) begin
            modeNext   = MODE_START;
            kindNext   = KIND_WARM;
            cmd.cntClr = 1'b1;
            cmd.toSet  = 1'b1;
            cmd.pdSet  = 1'b1;
          end else if (wakeEvt) begin
            modeNext   = MODE_START;
            kindNext   = KIND_WAKE;
            cmd.cntClr = 1'b1;
          end
        end
        default: begin
          if (cntDone) modeNext   = MODE_RUN;
          else         cmd.cntInc = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      mode <= MODE_START;
      kind <= KIND_COLD;
    end else begin
      mode <= modeNext;
      kind <= kindNext;
    end
  end

  assign cpuRun  = (mode == MODE_RUN);
  assign coldRst = (mode == MODE_START) && (kind == KIND_COLD);
  assign warmRst = (mode == MODE_START) && (kind == KIND_WARM);

  assert_run_after_count_R2: assert property (@(posedge clk) disable iff (!porN)
    (mode == MODE_START && cntDone && !pinLow) |=> cpuRun);

  assert_pin_holds_cold_R7: assert property (@(posedge clk) disable iff (!porN)
    pinLow |=> coldRst);
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic porN,
  input  logic pinRstN,
  input  logic wdtTimeout,
  input  logic haltCmd,
  input  logic wdtClr,
  input  logic wakeEvt,
  output logic coldRst,
  output logic warmRst,
  output logic cpuRun,
  output logic flagTo,
  output logic flagPd
);
  dpCmd_t cmd;
  logic   cntDone;

  rstseq_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .porN(porN), .pinRstN(pinRstN), .wdtTimeout(wdtTimeout),
    .haltCmd(haltCmd), .wdtClr(wdtClr), .wakeEvt(wakeEvt), .cntDone(cntDone),
    .cmd(cmd), .cpuRun(cpuRun), .coldRst(coldRst), .warmRst(warmRst)
  );

  rstseq_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .porN(porN), .cmd(cmd), .cntDone(cntDone),
    .flagTo(flagTo), .flagPd(flagPd)
  );

  // halted or waking: power-down flag must be set
  assert_halt_pd_R3: assert property (@(posedge clk) disable iff (!porN)
    (!cpuRun && !coldRst && !warmRst) |-> flagPd);

  assert_warm_flags_R5: assert property (@(posedge clk) disable iff (!porN)
    warmRst |-> (flagTo && flagPd));
endmodule

// File: tb/test_rstseq_top.sv
module test_rstseq_top;
  localparam int W    = 5;
  localparam int MAXC = (1 << W) - 1;

  logic clk = 1'b0;
  logic porN = 1'b0, pinRstN = 1'b1;
  logic wdtTimeout = 1'b0, haltCmd = 1'b0, wdtClr = 1'b0, wakeEvt = 1'b0;
  logic coldRst, warmRst, cpuRun, flagTo, flagPd;
  int   nChk = 0, nBad = 0;
  logic [4:0] obs;

  always #5 clk = ~clk;

  rstseq_top #(.CNT_W(W)) i_rstseq_top (
    .clk(clk), .porN(porN), .pinRstN(pinRstN), .wdtTimeout(wdtTimeout),
    .haltCmd(haltCmd), .wdtClr(wdtClr), .wakeEvt(wakeEvt),
    .coldRst(coldRst), .warmRst(warmRst), .cpuRun(cpuRun),
    .flagTo(flagTo), .flagPd(flagPd)
  );

  // {run, cold, warm, to, pd}
  assign obs = {cpuRun, coldRst, warmRst, flagTo, flagPd};

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: {run,cold,warm,to,pd} got %b expected %b", req, act, exp);
    end
  endtask

  task automatic setStrobes(input logic w, input logic h, input logic c, input logic k);
    wdtTimeout = w; haltCmd = h; wdtClr = c; wakeEvt = k;
  endtask

  // one strobe edge, returns at the negedge after it
  task automatic pulse(input logic w, input logic h, input logic c, input logic k);
    setStrobes(w, h, c, k);
    @(negedge clk);
    setStrobes(0, 0, 0, 0);
  endtask

  // called at the negedge after the event edge (counter = 0)
  task automatic startup(input string req, input logic cold, input logic warm,
                         input logic to, input logic pd, input int inj);
    for (int i = 1; i <= MAXC; i++) begin
      @(negedge clk);
      setStrobes(0, 0, 0, 0);
      check(req, obs, {1'b0, cold, warm, to, pd});
      if (i == inj) setStrobes(1, 1, 1, 1);   // R9: ignored during start-up
    end
    @(negedge clk);
    setStrobes(0, 0, 0, 0);
    check(req, obs, {1'b1, 1'b0, 1'b0, to, pd});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: run did not finish, got hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [4:0] exp;
    repeat (3) @(negedge clk);
    check("R1 reset state", obs, 5'b01000);
    porN = 1'b1;
    check("R1 after release", obs, 5'b01000);
    startup("R2 power-on start-up", 1, 0, 0, 0, -1);

    pulse(0, 1, 0, 0);
    check("R3 halt sets pd", obs, 5'b00001);
    pulse(0, 0, 1, 0);
    check("R9 clear ignored in halt", obs, 5'b00001);
    pulse(0, 0, 0, 1);
    check("R6 wake start", obs, 5'b00001);
    startup("R6 wake start-up", 0, 0, 0, 1, -1);
    pulse(0, 0, 1, 0);
    check("R3 clear pd", obs, 5'b10000);
    pulse(0, 0, 0, 1);
    check("R9 wake ignored in run", obs, 5'b10000);

    pulse(1, 0, 0, 0);
    check("R4 wdt in run", obs, 5'b01010);
    startup("R4 R9 cold start-up with strobes", 1, 0, 1, 0, 10);

    pulse(0, 1, 0, 0);
    check("R3 halt", obs, 5'b00011);
    pulse(1, 0, 0, 0);
    check("R5 wdt in halt", obs, 5'b00111);
    startup("R5 warm start-up", 0, 1, 1, 1, 7);

    pulse(0, 0, 1, 0);
    check("R3 clear", obs, 5'b10010);
    pinRstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 sync latency", obs, 5'b10010);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R7 pin held", obs, 5'b01010);
    end
    pinRstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 release", obs, 5'b01010);
    startup("R7 pin start-up", 1, 0, 1, 0, -1);

    pulse(0, 1, 0, 0);
    check("R3 halt again", obs, 5'b00011);
    pinRstN = 1'b0;
    repeat (2) @(negedge clk);
    pulse(1, 0, 0, 1);   // coincides with first synchronized low
    check("R8 R10 pin beats wdt in halt", obs, 5'b01001);
    pinRstN = 1'b1;
    repeat (2) @(negedge clk);
    startup("R8 pin wake start-up", 1, 0, 0, 1, -1);

    pulse(1, 0, 0, 0);
    repeat (4) @(negedge clk);
    porN = 1'b0;
    #1;
    check("R1 async power-on mid start-up", obs, 5'b01000);
    @(negedge clk);
    porN = 1'b1;
    startup("R1 R2 power-on restart", 1, 0, 0, 0, -1);

    // sweep: pre-state x strobe combos {wake,clr,halt,wdt}
    for (int h = 0; h < 2; h++) begin
      for (int c = 0; c < 16; c++) begin
        string req;
        porN = 1'b0;
        @(negedge clk);
        porN = 1'b1;
        repeat (MAXC + 1) @(negedge clk);
        if (h == 1) pulse(0, 1, 0, 0);
        pulse(c[0], c[1], c[2], c[3]);
        if (h == 0) begin
          if (c[0])      begin exp = 5'b01010; req = "R4 sweep"; end
          else if (c[1]) begin exp = 5'b00001; req = "R3 sweep"; end
          else if (c[2]) begin exp = 5'b10000; req = "R3 sweep clr"; end
          else           begin exp = 5'b10000; req = "R9 sweep"; end
        end else begin
          if (c[0])      begin exp = 5'b00111; req = "R5 R10 sweep"; end
          else if (c[3]) begin exp = 5'b00001; req = "R6 sweep"; end
          else           begin exp = 5'b00001; req = "R9 sweep halt"; end
        end
        check(req, obs, exp);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule